// File: doc/BRIEF.md
# Tearing-Effect Frame Start Trigger

This block decides when a display frame transfer may begin. A display panel reports its scan position through tearing-effect sync pulses. The block watches those pulses and issues a one-cycle start strobe once the panel's scan reaches a programmed line. Two sync wirings are supported. In the first, one shared line carries both the frame sync and the line syncs, and the block separates them by how long each pulse lasts. In the second, the frame sync and the line sync arrive on separate lines. When sync-based triggering is turned off, the strobe is raised directly by the rising edge of the enable input.

Each sync input passes through a two-stage synchronizer before its pulse is measured in core-clock ticks. A pulse is classified at its trailing edge. A frame sync clears the line count. Each line sync after it adds one to the count. The strobe fires once per frame, when the count reaches the programmed line number.

Top module: `te_start_trigger`

## Requirements
- R1: After reset, `start_o` is low, and it stays low until a trigger condition occurs.
- R2: With `trig_mode_i` = 0 (immediate), `start_o` is high for exactly one cycle. That cycle follows the first clock edge at which `enable_i` is sampled high after being low. Holding `enable_i` high produces no further strobes.
- R3: With `trig_mode_i` = 1 (shared line), a pulse on `te_frame_i` is measured in ticks. A pulse at least `vs_width_i` ticks long is a frame sync. A pulse shorter than that but at least `hs_width_i` ticks long is a line sync. A shorter pulse is ignored.
- R4: With `trig_mode_i` = 2 (split lines), a pulse on `te_frame_i` of at least `vs_width_i` ticks is a frame sync, and shorter ones are ignored. A pulse on `te_line_i` of at least `hs_width_i` ticks is a line sync. In mode 1, `te_line_i` has no effect.
- R5: A frame sync sets the line count to 0, and each line sync adds 1. The strobe fires when the count equals `line_num_i`. With `line_num_i` = 0, the frame sync itself fires. The strobe rises three clock edges after the trailing edge of the qualifying pulse is presented.
- R6: At most one strobe is issued per frame. Line syncs after the match do not fire again until the next frame sync. `line_num_i` = 2047, the largest 11-bit value, is reachable.
- R7: `vs_act_high_i` sets the active level of `te_frame_i`, and `hs_act_high_i` sets the active level of `te_line_i`. A bit value of 1 means active high and 0 means active low.
- R8: No sync-based strobe is issued when any of the following holds: `hs_width_i` < 2; `vs_width_i` < 4 in mode 1 or < 2 in mode 2; `hs_width_i` = `vs_width_i`; or `trig_mode_i` = 3.
- R9: While `enable_i` is low, no strobe is issued in modes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| te_frame_i | input | 1 | Shared sync line (mode 1) or frame sync line (mode 2) |
| te_line_i | input | 1 | Line sync line (mode 2 only) |
| trig_mode_i | input | 2 | 0 immediate, 1 shared line, 2 split lines, 3 reserved |
| hs_width_i | input | WW | Line sync width in ticks |
| vs_width_i | input | WW | Frame sync width in ticks |
| vs_act_high_i | input | 1 | Frame sync active level (1 = high) |
| hs_act_high_i | input | 1 | Line sync active level (1 = high) |
| line_num_i | input | LW | Line at which the strobe fires |
| enable_i | input | 1 | Trigger enable |
| start_o | output | 1 | One-cycle frame start strobe |

## Verification
A wrong internal state shows up only through `start_o`. A pulse counter that overruns or clears early misclassifies a sync pulse. That error appears as a strobe one line early, a strobe one line late, or a missing strobe. A line counter or arm flag that drifts shows up as a second strobe in the same frame or a strobe in the wrong frame. The bench's model predicts the strobe every cycle, so any such fault is reported at the first cycle where the strobe differs. At the latest, that is three edges after the trailing edge of the pulse that was misjudged.

// File: rtl/te_trig_pkg.sv
package te_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_NOW    = 2'd0,
    TRIG_SHARED = 2'd1,
    TRIG_SPLIT  = 2'd2,
    TRIG_RSVD   = 2'd3
  } trig_mode_e;

  // Legal sync-width settings for a sync-based mode
  function automatic logic sync_cfg_ok(logic [1:0] mode, logic [15:0] hs_w, logic [15:0] vs_w);
    logic [15:0] vs_min;
    vs_min = (mode == TRIG_SHARED) ? 16'd4 : 16'd2;
    return ((mode == TRIG_SHARED) || (mode == TRIG_SPLIT)) &&
           (hs_w >= 16'd2) && (vs_w >= vs_min) && (hs_w != vs_w);
  endfunction

endpackage

// File: rtl/te_sync_in.sv
module te_sync_in (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic act_high_i,
  output logic active_o
);
  logic stage1, stage2;

  // Polarity is normalised first, so reset leaves the line inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= pin_i ^ ~act_high_i;
      stage2 <= stage1;
    end
  end

  assign active_o = stage2;
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  output logic          done_o,
  output logic [WW-1:0] len_o
);
  localparam logic [WW-1:0] RUN_MAX = {WW{1'b1}};
  logic [WW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run <= '0;
    else if (!active_i)   run <= '0;
    else if (run != RUN_MAX) run <= run + 1'b1;
  end

  assign done_o = !active_i && (run != '0);
  assign len_o  = run;
endmodule

// File: rtl/te_line_tracker.sv
module te_line_tracker
  import te_trig_pkg::*;
#(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          cfg_ok_i,
  input  logic          enable_i,
  input  logic          vs_evt_i,
  input  logic          hs_evt_i,
  input  logic [LW-1:0] line_num_i,
  output logic          start_o
);
  localparam logic [LW-1:0] CNT_MAX = {LW{1'b1}};

  logic [LW-1:0] line_cnt, cnt_nxt;
  logic          armed, en_q;
  logic          at_max, match_vs, match_hs, fire_now, fire_te;

  assign at_max   = (line_cnt == CNT_MAX);
  assign cnt_nxt  = at_max ? line_cnt : line_cnt + 1'b1;
  assign match_vs = vs_evt_i && (line_num_i == '0);
  assign match_hs = !vs_evt_i && hs_evt_i && armed && !at_max && (cnt_nxt == line_num_i);
  assign fire_now = (mode_i == TRIG_NOW) && enable_i && !en_q;
  assign fire_te  = cfg_ok_i && enable_i && (match_vs || match_hs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      armed    <= 1'b0;
      en_q     <= 1'b0;
      start_o  <= 1'b0;
    end else begin
      en_q    <= enable_i;
      start_o <= fire_now || fire_te;
      if (vs_evt_i) begin
        line_cnt <= '0;
        armed    <= (line_num_i != '0);
      end else if (hs_evt_i) begin
        line_cnt <= cnt_nxt;
        if (match_hs) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/te_start_trigger.sv
module te_start_trigger
  import te_trig_pkg::*;
#(
  parameter int WW = 8,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          te_frame_i,
  input  logic          te_line_i,
  input  logic [1:0]    trig_mode_i,
  input  logic [WW-1:0] hs_width_i,
  input  logic [WW-1:0] vs_width_i,
  input  logic          vs_act_high_i,
  input  logic          hs_act_high_i,
  input  logic [LW-1:0] line_num_i,
  input  logic          enable_i,
  output logic          start_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] pin_v, pol_v, act_v, pulse_done;
  logic [WW-1:0]  pulse_len [NCH];
  logic           vs_evt, hs_evt, cfg_ok;

  assign pin_v = {te_line_i, te_frame_i};
  assign pol_v = {hs_act_high_i, vs_act_high_i};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    te_sync_in u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_v[ch]),
      .act_high_i(pol_v[ch]), .active_o(act_v[ch])
    );
    te_pulse_meter #(.WW(WW)) u_meter (
      .clk(clk), .rst_n(rst_n), .active_i(act_v[ch]),
      .done_o(pulse_done[ch]), .len_o(pulse_len[ch])
    );
  end

  assign cfg_ok = sync_cfg_ok(trig_mode_i, 16'(hs_width_i), 16'(vs_width_i));

  always_comb begin
    vs_evt = 1'b0;
    hs_evt = 1'b0;
    unique case (trig_mode_e'(trig_mode_i))
      TRIG_SHARED: begin
        vs_evt = pulse_done[0] && (pulse_len[0] >= vs_width_i);
        hs_evt = pulse_done[0] && (pulse_len[0] <  vs_width_i) && (pulse_len[0] >= hs_width_i);
      end
      TRIG_SPLIT: begin
        vs_evt = pulse_done[0] && (pulse_len[0] >= vs_width_i);
        hs_evt = pulse_done[1] && (pulse_len[1] >= hs_width_i);
      end
      default: ;
    endcase
  end

  te_line_tracker #(.LW(LW)) u_track (
    .clk(clk), .rst_n(rst_n), .mode_i(trig_mode_i), .cfg_ok_i(cfg_ok),
    .enable_i(enable_i), .vs_evt_i(vs_evt), .hs_evt_i(hs_evt),
    .line_num_i(line_num_i), .start_o(start_o)
  );
endmodule

// File: rtl/te_start_trigger_chk.sv
module te_start_trigger_chk #(
  parameter int WW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    trig_mode_i,
  input logic          enable_i,
  input logic [WW-1:0] hs_width_i,
  input logic          start_o,
  input logic          vs_evt,
  input logic          hs_evt,
  input logic          frame_done
);
  // R2
  imm_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_i == 2'd0 && $rose(enable_i)) |=> start_o);

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R3
  shared_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_i == 2'd1) |-> $onehot0({vs_evt, hs_evt}));

  // R4
  shared_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_i == 2'd1 && hs_evt) |-> frame_done);

  // R8
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_i == 2'd3) |=> !start_o);

  // R8
  narrow_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_i != 2'd0 && hs_width_i < 2) |=> !start_o);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !start_o);
endmodule

bind te_start_trigger te_start_trigger_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_mode_i(trig_mode_i), .enable_i(enable_i),
  .hs_width_i(hs_width_i), .start_o(start_o), .vs_evt(vs_evt),
  .hs_evt(hs_evt), .frame_done(pulse_done[0])
);

// File: tb/test_te_start_trigger.sv
module test_te_start_trigger;
  localparam int WW = 8;
  localparam int LW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic te_a = 1'b0, te_b = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [WW-1:0] hs_w = 8'd3, vs_w = 8'd8;
  logic pol_v = 1'b1, pol_h = 1'b1;
  logic [LW-1:0] line = 11'd2;
  logic en = 1'b0;
  logic start_o;

  int n_chk = 0, n_fail = 0, n_start = 0, mark = 0;
  bit done = 0;

  always #2 clk = ~clk;

  te_start_trigger #(.WW(WW), .LW(LW)) i_te_start_trigger (
    .clk(clk), .rst_n(rst_n), .te_frame_i(te_a), .te_line_i(te_b),
    .trig_mode_i(mode), .hs_width_i(hs_w), .vs_width_i(vs_w),
    .vs_act_high_i(pol_v), .hs_act_high_i(pol_h), .line_num_i(line),
    .enable_i(en), .start_o(start_o)
  );

  // Behavioural reference: delay lines, run lengths, line count
  int q_a[$], q_b[$];
  int ra, rb, lc;
  bit armed, en_prev, exp_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_a = '{0, 0}; q_b = '{0, 0};
      ra = 0; rb = 0; lc = 0; armed = 0; en_prev = 0; exp_start = 0;
    end else begin
      bit a_on, b_on, fsync, lsync, hit, legal;
      int vmin;
      a_on = (q_a[0] != 0); b_on = (q_b[0] != 0);
      fsync = 0; lsync = 0; hit = 0;
      if (mode == 1 || mode == 2) fsync = !a_on && ra > 0 && ra >= vs_w;
      if (mode == 1) lsync = !a_on && ra > 0 && ra < vs_w && ra >= hs_w;
      if (mode == 2) lsync = !b_on && rb > 0 && rb >= hs_w;
      vmin = (mode == 1) ? 4 : 2;
      legal = (mode == 1 || mode == 2) && hs_w >= 2 && vs_w >= vmin && hs_w != vs_w;
      if (fsync) begin
        lc = 0;
        if (line == 0) hit = 1;
        armed = (line != 0);
      end else if (lsync && lc < 2047) begin
        lc++;
        if (armed && lc == line) begin hit = 1; armed = 0; end
      end
      exp_start = (mode == 0 && en && !en_prev) || (hit && legal && en);
      en_prev = en;
      ra = a_on ? ((ra < 255) ? ra + 1 : 255) : 0;
      rb = b_on ? ((rb < 255) ? rb + 1 : 255) : 0;
      void'(q_a.pop_front()); q_a.push_back((te_a == pol_v) ? 1 : 0);
      void'(q_b.pop_front()); q_b.push_back((te_b == pol_h) ? 1 : 0);
    end
  end

  // R5 per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (start_o !== exp_start) begin
        n_fail++;
        $display("FAIL R5 model t=%0t start_o=%b expected=%b", $time, start_o, exp_start);
      end
      if (start_o === 1'b1) n_start++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pa(int len);
    @(negedge clk) te_a = pol_v;
    repeat (len) @(negedge clk);
    te_a = ~pol_v;
    idle(3);
  endtask

  task automatic pb(int len);
    @(negedge clk) te_b = pol_h;
    repeat (len) @(negedge clk);
    te_b = ~pol_h;
    idle(3);
  endtask

  task automatic expect_starts(string tag, int exp);
    int got;
    idle(8);
    got = n_start - mark;
    mark = n_start;
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s strobes=%0d expected=%0d", tag, got, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    n_chk++;
    if (start_o !== 1'b0) begin n_fail++; $display("FAIL R1 start_o=%b expected=0", start_o); end
    expect_starts("R1", 0);

    // R2 immediate trigger
    @(negedge clk) en = 1;
    expect_starts("R2 rise", 1);
    idle(20);
    expect_starts("R2 held", 0);
    @(negedge clk) en = 0;
    @(negedge clk) en = 1;
    expect_starts("R2 second rise", 1);
    @(negedge clk) en = 0;
    @(negedge clk) mode = 1;
    @(negedge clk) en = 1;
    expect_starts("R2 enable in mode1", 0);

    // R5 shared line: hs=3 vs=8 line=2
    pa(10); pa(4); pa(4);
    expect_starts("R5 line2", 1);
    pa(4); pa(4); pa(4);
    expect_starts("R6 extra lines", 0);
    pa(10); pa(4); pa(4);
    expect_starts("R6 next frame", 1);

    // R3 glitches and width boundaries
    pa(10); pa(4); pa(2); pa(2); pa(4);
    expect_starts("R3 glitch ignored", 1);
    pa(8); pa(7); pa(3);
    expect_starts("R3 width boundary", 1);

    // R4 split line ignored in mode 1
    pa(10); pb(4); pb(4); pb(4);
    expect_starts("R4 line pin in mode1", 0);

    // R5 line zero
    @(negedge clk) line = 0;
    pa(9);
    expect_starts("R5 line0", 1);
    pa(4);
    expect_starts("R5 line0 no repeat", 0);

    // R4 split mode: vs=4 hs=3 line=3
    @(negedge clk) begin mode = 2; vs_w = 4; hs_w = 3; line = 3; end
    pa(6); pb(4); pb(4); pb(4);
    expect_starts("R4 split", 1);
    pa(6); pb(4); pa(3); pb(4); pb(4);
    expect_starts("R4 short frame pulse", 1);

    // R7 active-low lines
    @(negedge clk) begin pol_v = 0; pol_h = 0; te_a = 1; te_b = 1; end
    idle(5);
    pa(6); pb(4); pb(4); pb(4);
    expect_starts("R7 active low", 1);
    @(negedge clk) begin pol_v = 1; pol_h = 1; te_a = 0; te_b = 0; end
    idle(5);
    expect_starts("R7 restore", 0);

    // R8 illegal settings
    @(negedge clk) begin hs_w = 4; vs_w = 4; end
    pa(6); pb(5); pb(5); pb(5);
    expect_starts("R8 equal widths", 0);
    @(negedge clk) begin hs_w = 1; vs_w = 4; end
    pa(6); pb(2); pb(2); pb(2);
    expect_starts("R8 hs below 2", 0);
    @(negedge clk) begin mode = 1; hs_w = 2; vs_w = 3; line = 1; end
    pa(5); pa(2);
    expect_starts("R8 vs below 4 mode1", 0);
    @(negedge clk) begin mode = 2; hs_w = 3; vs_w = 2; line = 3; end
    pa(3); pb(4); pb(4); pb(4);
    expect_starts("R8 vs 2 legal mode2", 1);
    @(negedge clk) mode = 3;
    pa(6); pb(4); pb(4); pb(4);
    expect_starts("R8 reserved mode", 0);

    // R9 disabled
    @(negedge clk) begin mode = 1; hs_w = 3; vs_w = 8; line = 2; en = 0; end
    pa(10); pa(4); pa(4);
    expect_starts("R9 disabled", 0);
    @(negedge clk) en = 1;

    // R6 top line number
    @(negedge clk) line = 11'd2047;
    pa(10);
    for (int i = 0; i < 2046; i++) pa(3);
    expect_starts("R6 before 2047", 0);
    pa(3);
    expect_starts("R6 at 2047", 1);
    pa(3);
    expect_starts("R6 past 2047", 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule